// File: doc/BRIEF.md
# Constant On-Time Switching Sequencer

This block is the digital sequencing core of a hysteretic step-down controller that has no oscillator. It works from synchronized single-bit inputs: a feedback comparator that reports the output below its reference, a valley current-limit comparator, and a zero-crossing comparator on the low-side switch. It also receives two digital codes, one for the sensed output voltage and one for the feed-forward voltage taken from the input supply. From these inputs it produces a high-side request and a low-side request. A downstream driver sequencer adds dead time and turns these requests into gate drive.

A high-side pulse begins only when three conditions hold on the same cycle: feedback is low, the minimum off-time has elapsed, and the current limit is not tripped. The pulse length is a one-shot whose cycle count is proportional to the sense code and inversely proportional to the clamped feed-forward code, plus a fixed delay. This keeps the switching frequency nearly constant as the input voltage varies. A free-running sequential divider computes that count from the present codes. Once the count runs out, the high side gives way to the low side. The low side then either stays on until the next pulse (forced-continuous mode) or releases at the zero crossing (pulse-skipping mode).

Top module: `cot_seq`

## Requirements
- R1: While rst_n or enable is low, hs_req and ls_req are both low on the cycle after enable is sampled low. After enable rises, the off-time is already satisfied, so a pulse may start on the first enabled edge.
- R2: A pulse starts (hs_req rises) only on an edge where enable=1, fb_low=1, ilim_trip=0, the minimum off-time has elapsed, and hs_req is low.
- R3: The on-time is ceil(K_CYC*sense_code/ffc) + DLY_CYC cycles, saturated to TON_MAX and never below 1. With the default parameters (K_CYC=50, DLY_CYC=14, TON_MAX=1023), sense=100 with ff=200 gives 39 cycles, and sense=7 with ff=3 gives 131 cycles.
- R4: The feed-forward code is clamped to FF_ONE_CODE (default 400) before division, and a code of 0 is treated as 1. So ff=600 gives the same 27 cycles as ff=400 when sense=100, and ff=0 saturates to 1023 cycles.
- R5: Once a pulse starts, hs_req stays high for the whole on-time, whatever fb_low and ilim_trip do.
- R6: On the edge where the on-time expires, hs_req falls and ls_req rises together.
- R7: After each high-side turn-off, hs_req stays low for at least MIN_OFF_CYC cycles (default 110).
- R8: With noskip=1, ls_req stays high from turn-off until the edge on which the next pulse starts, when it falls as hs_req rises.
- R9: With noskip=0, zc_det=1 during the low-side phase with no start pending drops ls_req on the next edge. Both requests then stay low until the next start.
- R10: While ilim_trip=1, no new pulse starts. The first pulse starts on the edge after ilim_trip clears, if the other conditions hold.
- R11: With fb_low held low, hs_req stays low. With fb_low held high, the rise-to-rise period equals on-time plus MIN_OFF_CYC.
- R12: hs_req and ls_req are never high together.
- R13: The on-time used is taken from the latest completed division. The codes must be stable for 2*(NUM_W+1) cycles before it reflects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low forces both requests off |
| noskip | input | 1 | 1 = forced-continuous, 0 = pulse-skipping |
| fb_low | input | 1 | Feedback below reference |
| ilim_trip | input | 1 | Valley current-limit comparator tripped |
| zc_det | input | 1 | Inductor current has reached zero |
| sense_code | input | CODE_W | Sensed output voltage code |
| ff_code | input | CODE_W | Feed-forward voltage code |
| hs_req | output | 1 | High-side switch request |
| ls_req | output | 1 | Low-side switch request |

## Verification
On every cycle, the assertions check the mutual exclusion of the two requests, the gating of each start by feedback, current limit and off-time, and the holding of the high side through the whole on-time. They also check the hand-over to the low side at expiry, the minimum off-time window (through a cycle counter in the checker), the zero-crossing release, and the forced-off state when disabled. Only the bench's scenarios can show that the pulse length matches the divide-and-round formula, including the clamp, the rounding and the saturation. The same holds for the exact heavy-demand period and for the first pulse following enable or a cleared current limit.

// File: rtl/cot_pkg.sv
`timescale 1ns/1ps
package cot_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  // Limit the divisor: never zero, never above the code for the clamp level.
  function automatic logic [31:0] ff_limit(input logic [31:0] ff, input logic [31:0] top);
    logic [31:0] v;
    v = ff;
    if (v == 32'd0) v = 32'd1;
    if (v > top)    v = top;
    return v;
  endfunction

  // Round the quotient up, add the fixed delay, saturate, and keep at least one cycle.
  function automatic logic [31:0] ton_finish(input logic [31:0] quo, input logic rem_nz,
                                             input logic [31:0] dly, input logic [31:0] tmax);
    logic [31:0] t;
    t = quo + {31'd0, rem_nz} + dly;
    if (t > tmax)   t = tmax;
    if (t == 32'd0) t = 32'd1;
    return t;
  endfunction

endpackage

// File: rtl/cot_ontime_div.sv
`timescale 1ns/1ps
module cot_ontime_div #(
  parameter int CODE_W      = 10,
  parameter int K_CYC       = 50,
  parameter int DLY_CYC     = 14,
  parameter int FF_ONE_CODE = 400,
  parameter int TON_MAX     = 1023,
  localparam int KW         = $clog2(K_CYC + 1),
  localparam int NUM_W      = CODE_W + KW,
  localparam int TON_W      = $clog2(TON_MAX + 1),
  localparam int STEP_W     = $clog2(NUM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sense_code,
  input  logic [CODE_W-1:0] ff_code,
  output logic [TON_W-1:0]  ton_cyc
);
  import cot_pkg::*;

  logic              busy;
  logic [STEP_W-1:0] step;
  logic [NUM_W-1:0]  num_sh;
  logic [NUM_W-1:0]  quo;
  logic [CODE_W-1:0] rem;
  logic [CODE_W-1:0] den;

  logic [CODE_W:0]   rem_sh;
  logic              take;
  logic [CODE_W:0]   rem_nx;
  logic [NUM_W-1:0]  quo_nx;
  logic [31:0]       fin;
  logic [31:0]       den_lim;
  logic              last_step;

  always_comb begin
    rem_sh    = {rem, num_sh[NUM_W-1]};
    take      = rem_sh >= {1'b0, den};
    rem_nx    = take ? (rem_sh - {1'b0, den}) : rem_sh;
    quo_nx    = {quo[NUM_W-2:0], take};
    last_step = busy && (step == STEP_W'(1));
    fin       = ton_finish(32'(quo_nx), |rem_nx, 32'(DLY_CYC), 32'(TON_MAX));
    den_lim   = ff_limit(32'(ff_code), 32'(FF_ONE_CODE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      step    <= '0;
      num_sh  <= '0;
      quo     <= '0;
      rem     <= '0;
      den     <= CODE_W'(1);
      ton_cyc <= TON_W'(1);
    end else if (!busy) begin
      busy   <= 1'b1;
      step   <= STEP_W'(NUM_W);
      num_sh <= NUM_W'(sense_code) * NUM_W'(K_CYC);
      quo    <= '0;
      rem    <= '0;
      den    <= den_lim[CODE_W-1:0];
    end else begin
      num_sh <= {num_sh[NUM_W-2:0], 1'b0};
      quo    <= quo_nx;
      rem    <= rem_nx[CODE_W-1:0];
      step   <= step - STEP_W'(1);
      if (last_step) begin
        busy    <= 1'b0;
        ton_cyc <= fin[TON_W-1:0];
      end
    end
  end

endmodule

// File: rtl/cot_offtime_timer.sv
`timescale 1ns/1ps
module cot_offtime_timer #(
  parameter int MIN_OFF_CYC = 110,
  localparam int OFF_W      = $clog2(MIN_OFF_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hs_fall,
  output logic off_done
);
  logic [OFF_W-1:0] off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                off_cnt <= '0;
    else if (!enable)          off_cnt <= '0;
    else if (hs_fall)          off_cnt <= OFF_W'(MIN_OFF_CYC - 1);
    else if (off_cnt != '0)    off_cnt <= off_cnt - OFF_W'(1);
  end

  assign off_done = (off_cnt == '0);

endmodule

// File: rtl/cot_phase_ctl.sv
`timescale 1ns/1ps
module cot_phase_ctl #(
  parameter int TON_MAX = 1023,
  localparam int TON_W  = $clog2(TON_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             noskip,
  input  logic             arm,
  input  logic             zc_det,
  input  logic [TON_W-1:0] ton_cyc,
  output logic             start_go,
  output logic             ton_last,
  output logic             hs_req,
  output logic             ls_req
);
  import cot_pkg::*;

  phase_e           phase;
  logic [TON_W-1:0] ton_left;
  logic             zc_release;

  assign start_go   = arm && (phase != PH_HIGH);
  assign ton_last   = (phase == PH_HIGH) && (ton_left <= TON_W'(1));
  assign zc_release = (phase == PH_LOW) && !noskip && zc_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ton_left <= '0;
    end else if (!enable) begin
      phase    <= PH_IDLE;
      ton_left <= '0;
    end else begin
      unique case (phase)
        PH_HIGH: begin
          if (ton_last) phase    <= PH_LOW;
          else          ton_left <= ton_left - TON_W'(1);
        end
        default: begin
          if (start_go) begin
            phase    <= PH_HIGH;
            ton_left <= ton_cyc;
          end else if (zc_release) begin
            phase <= PH_IDLE;
          end
        end
      endcase
    end
  end

  assign hs_req = (phase == PH_HIGH);
  assign ls_req = (phase == PH_LOW);

endmodule

// File: rtl/cot_seq.sv
`timescale 1ns/1ps
module cot_seq #(
  parameter int CODE_W      = 10,
  parameter int K_CYC       = 50,
  parameter int DLY_CYC     = 14,
  parameter int FF_ONE_CODE = 400,
  parameter int TON_MAX     = 1023,
  parameter int MIN_OFF_CYC = 110,
  localparam int TON_W      = $clog2(TON_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              noskip,
  input  logic              fb_low,
  input  logic              ilim_trip,
  input  logic              zc_det,
  input  logic [CODE_W-1:0] sense_code,
  input  logic [CODE_W-1:0] ff_code,
  output logic              hs_req,
  output logic              ls_req
);
  logic [TON_W-1:0] ton_cyc;
  logic             off_done;
  logic             arm;
  logic             start_go;
  logic             ton_last;

  assign arm = enable && fb_low && !ilim_trip && off_done;

  cot_ontime_div #(
    .CODE_W(CODE_W), .K_CYC(K_CYC), .DLY_CYC(DLY_CYC),
    .FF_ONE_CODE(FF_ONE_CODE), .TON_MAX(TON_MAX)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .sense_code(sense_code), .ff_code(ff_code), .ton_cyc(ton_cyc)
  );

  cot_offtime_timer #(.MIN_OFF_CYC(MIN_OFF_CYC)) u_off (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hs_fall(ton_last), .off_done(off_done)
  );

  cot_phase_ctl #(.TON_MAX(TON_MAX)) u_ph (
    .clk(clk), .rst_n(rst_n), .enable(enable), .noskip(noskip), .arm(arm),
    .zc_det(zc_det), .ton_cyc(ton_cyc), .start_go(start_go), .ton_last(ton_last),
    .hs_req(hs_req), .ls_req(ls_req)
  );

endmodule

// File: rtl/cot_seq_chk.sv
`timescale 1ns/1ps
module cot_seq_chk #(
  parameter int MIN_OFF_CYC = 110,
  localparam int LW         = $clog2(MIN_OFF_CYC + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic noskip,
  input logic fb_low,
  input logic ilim_trip,
  input logic zc_det,
  input logic hs_req,
  input logic ls_req,
  input logic start_go,
  input logic ton_last,
  input logic off_done
);
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           low_run <= LW'(MIN_OFF_CYC);
    else if (!enable)                     low_run <= LW'(MIN_OFF_CYC);
    else if (hs_req)                      low_run <= '0;
    else if (low_run < LW'(MIN_OFF_CYC))  low_run <= low_run + LW'(1);
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_req)); // R12
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_req) |-> $past(enable && fb_low && !ilim_trip && off_done)); // R2
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> hs_req); // R2
  AST_HS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_req && !ton_last && enable) |=> hs_req); // R5
  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (ton_last && enable) |=> (!hs_req && ls_req)); // R6
  AST_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_req) |-> (low_run >= LW'(MIN_OFF_CYC))); // R7
  AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_req && noskip && enable && !start_go) |=> ls_req); // R8
  AST_ZC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_req && !noskip && zc_det) |=> !ls_req); // R9
  AST_ILIM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_trip && !hs_req) |=> !hs_req); // R10
  AST_FB_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fb_low && !hs_req) |=> !hs_req); // R11
  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_req && !ls_req)); // R1

endmodule

bind cot_seq cot_seq_chk #(.MIN_OFF_CYC(MIN_OFF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .noskip(noskip), .fb_low(fb_low),
  .ilim_trip(ilim_trip), .zc_det(zc_det), .hs_req(hs_req), .ls_req(ls_req),
  .start_go(start_go), .ton_last(ton_last), .off_done(off_done)
);

// File: tb/cot_seq_tb.sv
`timescale 1ns/1ps
module cot_seq_tb_top;
  localparam int CW = 10;
  localparam int KC = 50, DC = 14, FONE = 400, TMAX = 1023, MOFF = 110;

  logic clk = 1'b0;
  logic rst_n, enable, noskip, fb_low, ilim_trip, zc_det;
  logic [CW-1:0] sense_code, ff_code;
  logic hs_req, ls_req;

  always #2.5 clk = ~clk;

  cot_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .noskip(noskip), .fb_low(fb_low),
    .ilim_trip(ilim_trip), .zc_det(zc_det), .sense_code(sense_code), .ff_code(ff_code),
    .hs_req(hs_req), .ls_req(ls_req)
  );

  int checks = 0, errs = 0;
  string cur_req = "R2";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Requirement formula restated with plain integers.
  function automatic int want_ton(input int s, input int f);
    int d, t;
    d = (f < 1) ? 1 : ((f > FONE) ? FONE : f);
    t = (KC * s) / d;
    if (t * d != KC * s) t = t + 1;
    t = t + DC;
    if (t > TMAX) t = TMAX;
    if (t < 1) t = 1;
    return t;
  endfunction

  // Behavioural reference: remaining high cycles and low cycles seen.
  bit m_hs, m_ls;
  int m_left, m_lowseen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !enable) begin
      m_hs = 0; m_ls = 0; m_left = 0; m_lowseen = MOFF;
    end else if (m_hs) begin
      m_left = m_left - 1;
      if (m_left == 0) begin m_hs = 0; m_ls = 1; m_lowseen = 1; end
    end else if (fb_low && !ilim_trip && m_lowseen >= MOFF) begin
      m_hs = 1; m_ls = 0; m_left = want_ton(int'(sense_code), int'(ff_code));
    end else begin
      if (m_lowseen < MOFF) m_lowseen = m_lowseen + 1;
      if (m_ls && !noskip && zc_det) m_ls = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({hs_req, ls_req} == {m_hs, m_ls}, cur_req, int'({hs_req, ls_req}), int'({m_hs, m_ls}));
      chk(!(hs_req && ls_req), "R12", int'({hs_req, ls_req}), 0);
    end
  end

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary_and_end();
  end

  task automatic set_codes(input int s, input int f);
    fb_low = 0;
    sense_code = CW'(s);
    ff_code = CW'(f);
    repeat (50) @(negedge clk); // R13: codes settle through the divider
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 5000 && !hs_req; i++) @(negedge clk);
  endtask

  task automatic hs_width(output int w);
    w = 0;
    while (hs_req && w < 5000) begin w++; @(negedge clk); end
  endtask

  task automatic low_width(output int w);
    w = 0;
    while (!hs_req && w < 5000) begin w++; @(negedge clk); end
  endtask

  int w, cnt;

  initial begin
    rst_n = 0; enable = 0; noskip = 1; fb_low = 0; ilim_trip = 0; zc_det = 0;
    sense_code = CW'(100); ff_code = CW'(200);
    repeat (5) @(negedge clk);
    chk(!hs_req && !ls_req, "R1", int'({hs_req, ls_req}), 0);
    rst_n = 1;
    repeat (50) @(negedge clk);
    chk(!hs_req && !ls_req, "R1", int'({hs_req, ls_req}), 0);

    cur_req = "R1";
    enable = 1; fb_low = 1;
    @(negedge clk);
    chk(hs_req, "R1", int'(hs_req), 1);
    cur_req = "R3";
    hs_width(w); chk(w == 39, "R3", w, 39);
    chk(ls_req, "R6", int'(ls_req), 1);
    cur_req = "R7";
    low_width(w); chk(w == MOFF, "R7", w, MOFF);
    cur_req = "R11";
    hs_width(w); chk(w == 39, "R11", w, 39);
    low_width(w); chk(w + 39 == 149, "R11", w + 39, 149);

    cur_req = "R8";
    hs_width(w);
    set_codes(100, 600);
    chk(ls_req && !hs_req, "R8", int'({hs_req, ls_req}), 1);
    cur_req = "R4";
    fb_low = 1; wait_rise(); hs_width(w); chk(w == 27, "R4", w, 27);
    set_codes(7, 3);
    cur_req = "R3";
    fb_low = 1; wait_rise(); hs_width(w); chk(w == 131, "R3", w, 131);
    set_codes(100, 0);
    cur_req = "R4";
    fb_low = 1; wait_rise(); hs_width(w); chk(w == TMAX, "R4", w, TMAX);

    set_codes(100, 200);
    cur_req = "R5";
    fb_low = 1; wait_rise();
    fb_low = 0; ilim_trip = 1;
    hs_width(w); chk(w == 39, "R5", w, 39);

    cur_req = "R10";
    fb_low = 1; cnt = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (hs_req) cnt++; end
    chk(cnt == 0, "R10", cnt, 0);
    ilim_trip = 0;
    @(negedge clk);
    chk(hs_req, "R10", int'(hs_req), 1);
    hs_width(w);
    fb_low = 0;

    cur_req = "R9";
    noskip = 0;
    repeat (5) @(negedge clk);
    chk(ls_req, "R9", int'(ls_req), 1);
    zc_det = 1; @(negedge clk); zc_det = 0;
    chk(!ls_req && !hs_req, "R9", int'({hs_req, ls_req}), 0);
    cnt = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk); if (hs_req || ls_req) cnt++; end
    chk(cnt == 0, "R9", cnt, 0);
    fb_low = 1; @(negedge clk);
    chk(hs_req, "R9", int'(hs_req), 1);

    cur_req = "R1";
    repeat (5) @(negedge clk);
    enable = 0; @(negedge clk);
    chk(!hs_req && !ls_req, "R1", int'({hs_req, ls_req}), 0);
    enable = 1; @(negedge clk);
    chk(hs_req, "R1", int'(hs_req), 1);
    hs_width(w);

    cur_req = "R11";
    noskip = 1; fb_low = 0; cnt = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (hs_req) cnt++; end
    chk(cnt == 0, "R11", cnt, 0);
    chk(ls_req, "R8", int'(ls_req), 1);

    summary_and_end();
  end

endmodule